// File: doc/BRIEF.md
# Indirect Address/Data Register Bridge

The bridge gives a host bus access to two larger internal register spaces through a small window of host-visible registers. Each of the two channels has an address register, a data register and a control register. The host places a target register index in the address register and then reads or writes the data register. The bridge turns those data-register accesses into transfers on a simple internal register bus. One channel serves a glue register space with 32-bit values. The other serves a controller register space whose registers hold 8-bit values.

A new address takes effect only after it has been written twice in a row. A read of an internal register is split across two host reads of the data register. The first read starts the internal fetch and returns the value that was already held. The second read returns the value just fetched. A write needs a single host write to the data register. Each channel checks the active index against the size of its space. Bit 15 of the channel's control register selects how a miss is handled: it either produces a bus error response, or it reads as zero and drops the write without any error.

The host side uses the two-phase select/enable handshake and completes every transfer without wait states. On the internal bus, a request pulses for one cycle. For a read, the target returns its data in the cycle after the request.

Top module: `regwin_bridge`

## Requirements
- R1: Channel select is host address bit 4 (0 = glue, 1 = controller). Address bits 3:2 select the register within the channel: 0 = address, 1 = data, 2 = control, 3 = reserved. The reserved slot reads zero, ignores writes and never raises an error.
- R2: The active index changes only when two consecutive address-register writes on a channel carry the same low 16 bits. Upper bits are ignored. Reading the address register returns the active index, zero-extended.
- R3: A lone address write leaves the active index unchanged, and so does a mismatched pair. Any other access to the same channel between the two writes breaks the pair. A data write after a lone address write uses the previously active index.
- R4: A data-register read that starts a sequence issues one internal read of the active index and returns the previously held value. The next data-register read issues no request and returns the value fetched by that internal read.
- R5: Any write to a channel's address register restarts its read sequence, so the next data read starts a new fetch.
- R6: One data-register write issues one internal write of the active index. The controller channel writes only the low 8 bits of the host data.
- R7: Control bit 15 reads back as written and resets to 0. All other control bits read as zero. Each channel has its own control bit.
- R8: When the active index is at or beyond the size of the channel's space and control bit 15 is set, a fetch-starting read or a data write returns an error response. No internal request is issued, and the held value becomes zero.
- R9: Under the same out-of-range condition with bit 15 clear, no error is returned and no internal request is issued. The read sequence then yields zero, and the write is dropped.
- R10: After reset, the active indices, the held values and the control bits are zero.
- R11: At most one channel issues an internal request in a cycle, and requests occur only in the access phase of a host transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Host select |
| penable | input | 1 | Host access phase |
| pwrite | input | 1 | Host write (1) or read (0) |
| paddr | input | 5 | Host byte address |
| pwdata | input | 32 | Host write data |
| prdata | output | 32 | Host read data, zero outside read access phases |
| pslverr | output | 1 | Error response in the access phase |
| glueReq | output | 1 | Glue internal request |
| glueWe | output | 1 | Glue internal write enable |
| glueAddr | output | 16 | Glue internal register index |
| glueWdata | output | 32 | Glue internal write data |
| glueRdata | input | 32 | Glue internal read data, valid the cycle after a read request |
| coreReq | output | 1 | Controller internal request |
| coreWe | output | 1 | Controller internal write enable |
| coreAddr | output | 16 | Controller internal register index |
| coreWdata | output | 8 | Controller internal write data |
| coreRdata | input | 8 | Controller internal read data, valid the cycle after a read request |

## Verification
Two events can land on the same host access: confirming an address and restarting a read sequence. The bench leaves a fetch half-finished by starting it with one data read and never reading again. It then confirms a new index and reads the data register. That read is judged correct only if it starts a fresh internal read of the new index and returns the stale held value, not the fetched result. A second overlap is an out-of-range error response on the fetch-starting read while the sequence still advances. Here the following read must return zero with no error.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  typedef enum logic [1:0] {
    SLOT_ADDR = 2'd0,
    SLOT_DATA = 2'd1,
    SLOT_CTRL = 2'd2,
    SLOT_RSVD = 2'd3
  } slot_e;

  // per-access strobes from a channel control to its datapath
  typedef struct packed {
    logic addrWr;
    logic ctrlWr;
    logic launch;
    logic dataWr;
    logic breakPair;
  } winStb_t;

  localparam int unsigned IDX_W      = 16;
  localparam int unsigned BUS_W      = 32;
  localparam int unsigned ERR_EN_BIT = 15;
endpackage

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    accEn,
  input  logic    isWrite,
  input  slot_e   slot,
  input  logic    inRange,
  input  logic    errEn,
  output winStb_t stb,
  output logic    slvErr
);
  logic rdPend;
  logic dataRd;
  logic finishRd;

  always_comb begin
    dataRd        = accEn && !isWrite && (slot == SLOT_DATA);
    stb.addrWr    = accEn && isWrite && (slot == SLOT_ADDR);
    stb.ctrlWr    = accEn && isWrite && (slot == SLOT_CTRL);
    stb.dataWr    = accEn && isWrite && (slot == SLOT_DATA);
    stb.launch    = dataRd && !rdPend;
    stb.breakPair = accEn && !(isWrite && (slot == SLOT_ADDR));
    finishRd      = dataRd && rdPend;
    slvErr        = (stb.launch || stb.dataWr) && !inRange && errEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              rdPend <= 1'b0;
    else if (stb.addrWr || stb.dataWr)      rdPend <= 1'b0;
    else if (stb.launch)                    rdPend <= 1'b1;
    else if (finishRd)                      rdPend <= 1'b0;
  end
endmodule

// File: rtl/regwin_dpath.sv
module regwin_dpath
  import regwin_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  winStb_t            stb,
  input  slot_e              slot,
  input  logic [BUS_W-1:0]   wdata,
  input  logic [DATA_W-1:0]  iRdata,
  output logic               iReq,
  output logic               iWe,
  output logic [IDX_W-1:0]   iAddr,
  output logic [DATA_W-1:0]  iWdata,
  output logic               inRange,
  output logic               errEn,
  output logic [BUS_W-1:0]   rdWord
);
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(DEPTH);

  logic [IDX_W-1:0]  activeIdx;
  logic [IDX_W-1:0]  stageIdx;
  logic              stageVld;
  logic [DATA_W-1:0] heldVal;
  logic              capNext;
  logic              unusedWdata;

  assign unusedWdata = ^wdata;
  assign inRange = {1'b0, activeIdx} < LIMIT;
  assign iReq    = (stb.launch || stb.dataWr) && inRange;
  assign iWe     = stb.dataWr && inRange;
  assign iAddr   = activeIdx;
  assign iWdata  = wdata[DATA_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeIdx <= '0;
      stageIdx  <= '0;
      stageVld  <= 1'b0;
    end else if (stb.addrWr) begin
      if (stageVld && (wdata[IDX_W-1:0] == stageIdx)) begin
        activeIdx <= stageIdx;
        stageVld  <= 1'b0;
      end else begin
        stageIdx <= wdata[IDX_W-1:0];
        stageVld <= 1'b1;
      end
    end else if (stb.breakPair) begin
      stageVld <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldVal <= '0;
      capNext <= 1'b0;
    end else begin
      capNext <= stb.launch && inRange;
      if (stb.launch && !inRange) heldVal <= '0;
      else if (capNext)           heldVal <= iRdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           errEn <= 1'b0;
    else if (stb.ctrlWr) errEn <= wdata[ERR_EN_BIT];
  end

  always_comb begin
    rdWord = '0;
    unique case (slot)
      SLOT_ADDR: rdWord[IDX_W-1:0]  = activeIdx;
      SLOT_DATA: rdWord[DATA_W-1:0] = heldVal;
      SLOT_CTRL: rdWord[ERR_EN_BIT] = errEn;
      default:   rdWord = '0;
    endcase
  end
endmodule

// File: rtl/regwin_bridge.sv
module regwin_bridge
  import regwin_pkg::*;
#(
  parameter int unsigned GLUE_DEPTH = 16,
  parameter int unsigned CORE_DEPTH = 256,
  parameter int unsigned GLUE_W     = 32,
  parameter int unsigned CORE_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [4:0]        paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pslverr,
  output logic              glueReq,
  output logic              glueWe,
  output logic [15:0]       glueAddr,
  output logic [GLUE_W-1:0] glueWdata,
  input  logic [GLUE_W-1:0] glueRdata,
  output logic              coreReq,
  output logic              coreWe,
  output logic [15:0]       coreAddr,
  output logic [CORE_W-1:0] coreWdata,
  input  logic [CORE_W-1:0] coreRdata
);
  localparam int unsigned NUM_CH = 2;

  logic             access;
  logic             chanSel;
  slot_e            slot;
  logic             unusedAddr;
  logic [BUS_W-1:0] rdWord [NUM_CH];
  logic [NUM_CH-1:0] errVec;

  assign access     = psel && penable;
  assign chanSel    = paddr[4];
  assign slot       = slot_e'(paddr[3:2]);
  assign unusedAddr = ^paddr[1:0];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    winStb_t stb;
    logic    inRange;
    logic    errEn;
    logic    accEn;

    assign accEn = access && (chanSel == 1'(ch));

    regwin_ctrl u_ctrl (
      .clk     (clk),
      .rstN    (rstN),
      .accEn   (accEn),
      .isWrite (pwrite),
      .slot    (slot),
      .inRange (inRange),
      .errEn   (errEn),
      .stb     (stb),
      .slvErr  (errVec[ch])
    );

    if (ch == 0) begin : g_glue
      regwin_dpath #(.DATA_W(GLUE_W), .DEPTH(GLUE_DEPTH)) u_dpath (
        .clk     (clk),
        .rstN    (rstN),
        .stb     (stb),
        .slot    (slot),
        .wdata   (pwdata),
        .iRdata  (glueRdata),
        .iReq    (glueReq),
        .iWe     (glueWe),
        .iAddr   (glueAddr),
        .iWdata  (glueWdata),
        .inRange (inRange),
        .errEn   (errEn),
        .rdWord  (rdWord[ch])
      );
    end else begin : g_core
      regwin_dpath #(.DATA_W(CORE_W), .DEPTH(CORE_DEPTH)) u_dpath (
        .clk     (clk),
        .rstN    (rstN),
        .stb     (stb),
        .slot    (slot),
        .wdata   (pwdata),
        .iRdata  (coreRdata),
        .iReq    (coreReq),
        .iWe     (coreWe),
        .iAddr   (coreAddr),
        .iWdata  (coreWdata),
        .inRange (inRange),
        .errEn   (errEn),
        .rdWord  (rdWord[ch])
      );
    end
  end

  assign prdata  = (access && !pwrite) ? rdWord[chanSel] : '0;
  assign pslverr = errVec[chanSel];
endmodule

// File: rtl/regwin_chk.sv
module regwin_chk #(
  parameter int unsigned GLUE_DEPTH = 16,
  parameter int unsigned CORE_DEPTH = 256
) (
  input logic        clk,
  input logic        rstN,
  input logic        psel,
  input logic        penable,
  input logic        pwrite,
  input logic [4:0]  paddr,
  input logic [31:0] prdata,
  input logic        pslverr,
  input logic        glueReq,
  input logic [15:0] glueAddr,
  input logic        coreReq,
  input logic        coreWe,
  input logic [15:0] coreAddr
);
  // R8
  glue_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    glueReq |-> ({16'd0, glueAddr} < 32'(GLUE_DEPTH)));

  // R9
  core_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    coreReq |-> ({16'd0, coreAddr} < 32'(CORE_DEPTH)));

  // R11
  one_channel_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({glueReq, coreReq}));

  // R11
  req_in_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    (glueReq || coreReq) |-> (psel && penable));

  // R8
  err_on_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    pslverr |-> (psel && penable && paddr[3:2] == 2'd1));

  // R6
  core_write_from_host_chk: assert property (@(posedge clk) disable iff (!rstN)
    (coreReq && coreWe) |-> pwrite);

  // R1
  idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(psel && penable && !pwrite) |-> (prdata == 32'd0));
endmodule

bind regwin_bridge regwin_chk #(.GLUE_DEPTH(GLUE_DEPTH), .CORE_DEPTH(CORE_DEPTH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .psel     (psel),
  .penable  (penable),
  .pwrite   (pwrite),
  .paddr    (paddr),
  .prdata   (prdata),
  .pslverr  (pslverr),
  .glueReq  (glueReq),
  .glueAddr (glueAddr),
  .coreReq  (coreReq),
  .coreWe   (coreWe),
  .coreAddr (coreAddr)
);

// File: tb/regwin_bridge_tb.sv
module regwin_bridge_tb;
  localparam logic [4:0] G_A = 5'h00, G_D = 5'h04, G_C = 5'h08, G_R = 5'h0C;
  localparam logic [4:0] C_A = 5'h10, C_D = 5'h14, C_C = 5'h18;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [4:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pslverr;
  logic glueReq, glueWe, coreReq, coreWe;
  logic [15:0] glueAddr, coreAddr;
  logic [31:0] glueWdata, glueRdata;
  logic [7:0] coreWdata, coreRdata;

  logic [31:0] glueMem [16];
  logic [7:0]  coreMem [256];
  logic [31:0] refGlue [16];
  logic [7:0]  refCore [256];

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  typedef struct {
    bit chkRd; logic [31:0] rd; logic err; int req;
  } hostExp_t;
  typedef struct {
    int ch; logic we; logic [15:0] addr; logic [31:0] wd; int req;
  } opExp_t;
  hostExp_t hostQ[$];
  opExp_t   opQ[$];

  always #2.5 clk = ~clk;

  regwin_bridge u_dut (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pslverr(pslverr),
    .glueReq(glueReq), .glueWe(glueWe), .glueAddr(glueAddr),
    .glueWdata(glueWdata), .glueRdata(glueRdata),
    .coreReq(coreReq), .coreWe(coreWe), .coreAddr(coreAddr),
    .coreWdata(coreWdata), .coreRdata(coreRdata)
  );

  // behavioural internal register spaces, read data one cycle after request
  always_ff @(posedge clk) begin
    if (glueReq && glueWe) glueMem[glueAddr[3:0]] <= glueWdata;
    if (glueReq && !glueWe) glueRdata <= glueMem[glueAddr[3:0]];
    if (coreReq && coreWe) coreMem[coreAddr[7:0]] <= coreWdata;
    if (coreReq && !coreWe) coreRdata <= coreMem[coreAddr[7:0]];
  end

  task automatic hostXfer(input logic wr, input logic [4:0] a, input logic [31:0] d);
    @(posedge clk);
    psel <= 1'b1; penable <= 1'b0; pwrite <= wr; paddr <= a; pwdata <= d;
    @(posedge clk);
    penable <= 1'b1;
    @(posedge clk);
    psel <= 1'b0; penable <= 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input logic err, input int req);
    hostExp_t e;
    e.chkRd = 1'b1; e.rd = exp; e.err = err; e.req = req;
    hostQ.push_back(e);
    hostXfer(1'b0, a, 32'd0);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic err, input int req);
    hostExp_t e;
    e.chkRd = 1'b0; e.rd = '0; e.err = err; e.req = req;
    hostQ.push_back(e);
    hostXfer(1'b1, a, d);
  endtask

  task automatic expOp(input int ch, input logic we, input logic [15:0] a,
                       input logic [31:0] d, input int req);
    opExp_t o;
    o.ch = ch; o.we = we; o.addr = a; o.wd = d; o.req = req;
    opQ.push_back(o);
    if (we && ch == 0) refGlue[a[3:0]] = d;
    if (we && ch == 1) refCore[a[7:0]] = d[7:0];
  endtask

  task automatic confirm(input logic [4:0] a, input logic [31:0] v, input int req);
    wr(a, v, 1'b0, req);
    wr(a, v, 1'b0, req);
  endtask

  // monitor for host-side results
  always @(negedge clk) begin
    if (rstN && psel && penable) begin
      if (hostQ.size() == 0) begin
        miscompares++;
        $display("FAIL R1 unexpected host access actual=%h expected=none", prdata);
      end else begin
        hostExp_t e;
        e = hostQ.pop_front();
        vectors++;
        if ((e.chkRd && prdata !== e.rd) || pslverr !== e.err) begin
          miscompares++;
          $display("FAIL R%0d host actual=%h/%b expected=%h/%b", e.req, prdata, pslverr, e.rd, e.err);
        end
      end
    end
  end

  // monitor for internal bus requests
  always @(negedge clk) begin
    if (rstN && (glueReq || coreReq)) begin
      int ch;
      logic we;
      logic [15:0] a;
      logic [31:0] d;
      ch = coreReq ? 1 : 0;
      we = coreReq ? coreWe : glueWe;
      a  = coreReq ? coreAddr : glueAddr;
      d  = coreReq ? {24'd0, coreWdata} : glueWdata;
      if (opQ.size() == 0) begin
        miscompares++;
        $display("FAIL R11 unexpected request actual=ch%0d we%b %h expected=none", ch, we, a);
      end else begin
        opExp_t o;
        o = opQ.pop_front();
        vectors++;
        if (ch != o.ch || we !== o.we || a !== o.addr || (we && d !== o.wd)) begin
          miscompares++;
          $display("FAIL R%0d op actual=ch%0d we%b %h %h expected=ch%0d we%b %h %h",
                   o.req, ch, we, a, d, o.ch, o.we, o.addr, o.wd);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      glueMem[i] = 32'hC0DE0000 + 32'(i);
      refGlue[i] = 32'hC0DE0000 + 32'(i);
    end
    for (int i = 0; i < 256; i++) begin
      coreMem[i] = 8'(i) ^ 8'h5A;
      refCore[i] = 8'(i) ^ 8'h5A;
    end
    repeat (3) @(posedge clk);
    rstN <= 1'b1;

    // R10 reset state, R1 reserved slot
    rd(G_A, 32'd0, 1'b0, 10);
    rd(G_C, 32'd0, 1'b0, 10);
    rd(G_R, 32'd0, 1'b0, 1);
    expOp(1, 1'b0, 16'd0, 32'd0, 10);
    rd(C_D, 32'd0, 1'b0, 10);
    rd(C_D, {24'd0, refCore[0]}, 1'b0, 4);

    // R2 pair with ignored upper bits
    wr(G_A, 32'hABCD0003, 1'b0, 2);
    wr(G_A, 32'h12340003, 1'b0, 2);
    rd(G_A, 32'd3, 1'b0, 2);

    // R3 lone, broken and mismatched writes
    wr(G_A, 32'd5, 1'b0, 3);
    rd(G_A, 32'd3, 1'b0, 3);
    wr(G_A, 32'd7, 1'b0, 3);
    wr(G_A, 32'd8, 1'b0, 3);
    rd(G_A, 32'd3, 1'b0, 3);
    confirm(G_A, 32'd9, 2);
    rd(G_A, 32'd9, 1'b0, 2);

    // R4 two-step read
    expOp(0, 1'b0, 16'd9, 32'd0, 4);
    rd(G_D, 32'd0, 1'b0, 4);
    rd(G_D, refGlue[9], 1'b0, 4);

    // R5 address confirm restarts a half-done sequence
    expOp(0, 1'b0, 16'd9, 32'd0, 5);
    rd(G_D, refGlue[9], 1'b0, 5);
    confirm(G_A, 32'd2, 5);
    expOp(0, 1'b0, 16'd2, 32'd0, 5);
    rd(G_D, refGlue[9], 1'b0, 5);
    rd(G_D, refGlue[2], 1'b0, 5);

    // R6 single data write
    expOp(0, 1'b1, 16'd2, 32'hDEAD0002, 6);
    wr(G_D, 32'hDEAD0002, 1'b0, 6);
    expOp(0, 1'b0, 16'd2, 32'd0, 6);
    rd(G_D, 32'hC0DE0002, 1'b0, 6);
    rd(G_D, refGlue[2], 1'b0, 6);

    // R6 controller channel truncates to 8 bits, R1 channels independent
    confirm(C_A, 32'h00000040, 6);
    expOp(1, 1'b1, 16'h0040, 32'h000000F7, 6);
    wr(C_D, 32'h123456F7, 1'b0, 6);
    expOp(1, 1'b0, 16'h0040, 32'd0, 6);
    rd(C_D, {24'd0, refCore[0]}, 1'b0, 6);
    rd(C_D, 32'h000000F7, 1'b0, 6);
    rd(G_A, 32'd2, 1'b0, 1);
    rd(C_A, 32'h40, 1'b0, 1);

    // R3 data write after a lone address write keeps old index
    wr(C_A, 32'h41, 1'b0, 3);
    expOp(1, 1'b1, 16'h0040, 32'h11, 3);
    wr(C_D, 32'h11, 1'b0, 3);
    rd(C_A, 32'h40, 1'b0, 3);

    // R7 control bit
    wr(G_C, 32'hFFFFFFFF, 1'b0, 7);
    rd(G_C, 32'h00008000, 1'b0, 7);
    rd(C_C, 32'd0, 1'b0, 7);

    // R8 out of range with error enabled
    confirm(G_A, 32'd20, 8);
    rd(G_D, 32'hDEAD0002, 1'b1, 8);
    rd(G_D, 32'd0, 1'b0, 8);
    wr(G_D, 32'h55, 1'b1, 8);

    // R9 out of range with error disabled
    confirm(C_A, 32'h012C, 9);
    rd(C_D, 32'h000000F7, 1'b0, 9);
    rd(C_D, 32'd0, 1'b0, 9);
    wr(C_D, 32'h77, 1'b0, 9);
    confirm(C_A, 32'h40, 9);
    expOp(1, 1'b0, 16'h0040, 32'd0, 9);
    rd(C_D, 32'd0, 1'b0, 9);
    rd(C_D, 32'h11, 1'b0, 9);

    // R1 reserved write ignored
    wr(G_R, 32'h0000FFFF, 1'b0, 1);
    rd(G_C, 32'h00008000, 1'b0, 1);
    rd(G_A, 32'd20, 1'b0, 1);

    repeat (4) @(posedge clk);
    vectors++;
    if (hostQ.size() != 0 || opQ.size() != 0) begin
      miscompares++;
      $display("FAIL R11 leftover expectations actual=%0d/%0d expected=0/0", hostQ.size(), opQ.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule